// File: doc/BRIEF.md
# Elapsed Time Counter with Alarm

This block is the timekeeping core of a real-time clock. A 48-bit counter advances by one on every cycle in which a 32.768 kHz tick enable is high, so bits 47:15 of the count are whole seconds and bits 14:0 are fractions of a second. Software sees the counter as three 16-bit words on a simple word-wide register bus, and it can overwrite any one of those words on its own.

A second 48-bit value, the alarm compare, uses the same three-word layout. When the running count first becomes equal to the compare value, a sticky alarm flag sets. Software clears the flag by writing a one to it. The interrupt output is raised while the flag is set and the alarm enable bit is also set.

Reads are not latched across words. To obtain a coherent 48-bit time, software reads all three words twice and repeats until both passes agree. Each single word is always returned whole from the live register.

Top module: `rtc_elapsed_core`

## Requirements
- R1: After reset, all three counter words, all three compare words, the alarm flag, the enable bit and `alarm_irq` read as zero.
- R2: Each clock cycle with `tick` high and no counter-word write adds one to the 48-bit count. The count is read as three words: byte offset 0x00 holds bits 15:0, 0x02 holds bits 31:16 and 0x04 holds bits 47:32. Whole seconds therefore start at bit 15 of the word at 0x00, so 32768 ticks from zero read 0x8000 there.
- R3: A carry propagates across word boundaries. 0x0000_0000_FFFF plus one tick gives 0x0000_0001_0000, and 0x0000_FFFF_FFFF plus one tick gives 0x0001_0000_0000.
- R4: At 0xFFFF_FFFF_FFFF, one more tick wraps the count to zero.
- R5: A bus write to a counter word loads the written data into that word only. The other two words keep their values, and the count does not move in cycles with neither a tick nor a write.
- R6: If a counter-word write and a tick fall in the same cycle, the write wins. The written word takes the bus data, and the other words keep their values without incrementing.
- R7: The compare value is written and read back at byte offsets 0x08, 0x0A and 0x0C, with the same word layout as the counter.
- R8: The alarm flag (bit 0 of the status word at 0x10) sets one cycle after the count first becomes equal to the compare value. It is not set while the two differ.
- R9: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged. If a new match arrives in the same cycle as the clear, the set wins.
- R10: The enable bit is bit 0 of the word at 0x12. `alarm_irq` is high exactly when the flag and the enable bit are both 1.
- R11: The flag sets only on entry into equality. If it is cleared while the count still equals the compare value, it stays clear.
- R12: Bits 15:1 of the status and enable words, and every unmapped offset, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 32.768 kHz count enable, one cycle wide |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, together with bus_sel |
| bus_addr | input | 5 | Byte offset of the 16-bit register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The hardest conditions to reach are carries out of the upper words and the wrap of the full 48-bit count. Reaching them by ticking alone would take billions of cycles. The bench instead preloads individual counter words just below each boundary and then applies one tick or a short burst of ticks. The alarm is swept across a range of compare offsets, checking the flag one cycle before and one cycle after the count reaches the compare value. The bench also clears the flag while the stopped count still equals the compare value, which shows that equality alone does not set it again.

// File: rtl/rtc_elapsed_pkg.sv
package rtc_elapsed_pkg;
    // Byte offsets of the register groups
    localparam int CNT_BASE  = 'h00;
    localparam int CMP_BASE  = 'h08;
    localparam int STAT_OFFS = 'h10;
    localparam int EN_OFFS   = 'h12;
    // Byte stride between adjacent 16-bit words
    localparam int WORD_STRIDE = 2;
endpackage

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
    parameter int CNT_W  = 48,
    parameter int WORD_W = 16,
    localparam int NW    = CNT_W / WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NW-1:0]     word_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (|word_we) begin
            for (int i = 0; i < NW; i++) begin
                if (word_we[i]) st_d.cnt[i*WORD_W +: WORD_W] = wdata;
            end
        end else if (tick) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/rtc_alarm_compare.sv
module rtc_alarm_compare #(
    parameter int CNT_W  = 48,
    parameter int WORD_W = 16,
    localparam int NW    = CNT_W / WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NW-1:0]     word_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cmp_value,
    output logic              match
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             eq;   // equality seen in the previous cycle
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       eq_now;

    always_comb begin
        eq_now = (count == st_q.cmp);
        match  = eq_now && !st_q.eq;
        st_d    = st_q;
        st_d.eq = eq_now;
        for (int i = 0; i < NW; i++) begin
            if (word_we[i]) st_d.cmp[i*WORD_W +: WORD_W] = wdata;
        end
    end

    // eq resets high: count and compare both reset to zero, which is not an alarm
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmp <= '0;
            st_q.eq  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_value = st_q.cmp;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic stat_we,
    input  logic en_we,
    input  logic wbit,
    output logic flag,
    output logic enable,
    output logic irq
);
    typedef struct packed {
        logic flag;
        logic en;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (match)                st_d.flag = 1'b1;
        else if (stat_we && wbit) st_d.flag = 1'b0;
        if (en_we)                st_d.en   = wbit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag   = st_q.flag;
    assign enable = st_q.en;
    assign irq    = st_q.flag & st_q.en;
endmodule

// File: rtl/rtc_elapsed_core.sv
module rtc_elapsed_core #(
    parameter int CNT_W  = 48,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              alarm_irq
);
    import rtc_elapsed_pkg::*;

    localparam int NW = CNT_W / WORD_W;
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFFS);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFFS);

    logic             wr;
    logic [NW-1:0]    cnt_hit, cmp_hit;
    logic [CNT_W-1:0] cnt_value, cmp_value;
    logic             match, flag, en;

    assign wr = bus_sel && bus_we;

    for (genvar i = 0; i < NW; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(CNT_BASE + WORD_STRIDE*i);
        localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(CMP_BASE + WORD_STRIDE*i);
        assign cnt_hit[i] = (bus_addr == CNT_A);
        assign cmp_hit[i] = (bus_addr == CMP_A);
    end

    rtc_tick_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .word_we (cnt_hit & {NW{wr}}),
        .wdata   (bus_wdata),
        .count   (cnt_value)
    );

    rtc_alarm_compare #(.CNT_W(CNT_W), .WORD_W(WORD_W)) i_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_we   (cmp_hit & {NW{wr}}),
        .wdata     (bus_wdata),
        .count     (cnt_value),
        .cmp_value (cmp_value),
        .match     (match)
    );

    rtc_alarm_irq i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .match   (match),
        .stat_we (wr && (bus_addr == STAT_A)),
        .en_we   (wr && (bus_addr == EN_A)),
        .wbit    (bus_wdata[0]),
        .flag    (flag),
        .enable  (en),
        .irq     (alarm_irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NW; i++) begin
            if (cnt_hit[i]) bus_rdata = cnt_value[i*WORD_W +: WORD_W];
            if (cmp_hit[i]) bus_rdata = cmp_value[i*WORD_W +: WORD_W];
        end
        if (bus_addr == STAT_A) bus_rdata = {{(WORD_W-1){1'b0}}, flag};
        if (bus_addr == EN_A)   bus_rdata = {{(WORD_W-1){1'b0}}, en};
    end
endmodule

// File: rtl/rtc_elapsed_checker.sv
module rtc_elapsed_checker #(
    parameter int CNT_W  = 48,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  cnt_value,
    input logic [CNT_W-1:0]  cmp_value,
    input logic              flag,
    input logic              en,
    input logic              alarm_irq
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    logic wr, cnt_wr, cmp_wr, stat_clr;
    assign wr       = bus_sel && bus_we;
    assign cnt_wr   = wr && (bus_addr < ADDR_W'(6));
    assign cmp_wr   = wr && (bus_addr >= ADDR_W'(8)) && (bus_addr < ADDR_W'(14));
    assign stat_clr = wr && (bus_addr == ADDR_W'(16)) && bus_wdata[0];

    // R2
    cnt_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (cnt_value == $past(cnt_value) + ONE));

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt_value));

    // R7
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_wr |=> $stable(cmp_value));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && (cnt_value != cmp_value)) |=> !flag);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !stat_clr) |=> flag);

    // R11
    no_false_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && (cnt_value != cmp_value)) |=> !flag);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (flag && en));
endmodule

bind rtc_elapsed_core rtc_elapsed_checker #(
    .CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_value (cnt_value),
    .cmp_value (cmp_value),
    .flag      (flag),
    .en        (en),
    .alarm_irq (alarm_irq)
);

// File: tb/test_rtc_elapsed_core.sv
`timescale 1ns/1ps
module test_rtc_elapsed_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        alarm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_elapsed_core i_rtc_elapsed_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_cnt(input logic [47:0] v);
        wr(5'h00, v[15:0]); wr(5'h02, v[31:16]); wr(5'h04, v[47:32]);
    endtask

    task automatic set_cmp(input logic [47:0] v);
        wr(5'h08, v[15:0]); wr(5'h0A, v[31:16]); wr(5'h0C, v[47:32]);
    endtask

    task automatic check_cnt(input string req, input logic [47:0] v);
        logic [15:0] d;
        rd(5'h00, d); check(req, d, v[15:0]);
        rd(5'h02, d); check(req, d, v[31:16]);
        rd(5'h04, d); check(req, d, v[47:32]);
    endtask

    // n consecutive cycles with tick high, ends at a negedge
    task automatic burst(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_cnt("R1 cnt", 48'h0);
        rd(5'h08, d); check("R1 cmp0", d, 16'h0);
        rd(5'h0A, d); check("R1 cmp1", d, 16'h0);
        rd(5'h0C, d); check("R1 cmp2", d, 16'h0);
        rd(5'h10, d); check("R1 flag", d, 16'h0);
        rd(5'h12, d); check("R1 en", d, 16'h0);
        check("R1 irq", {15'h0, alarm_irq}, 16'h0);

        // Move compare away so the counting sweeps do not raise the alarm
        set_cmp(48'hAAAA_0000_0000);

        // R2 tick sweep and seconds position
        for (int n = 1; n <= 9; n++) begin
            set_cnt(48'h0);
            burst(n);
            check_cnt("R2 sweep", 48'(n));
        end
        set_cnt(48'h0);
        burst(32768);
        check_cnt("R2 one second", 48'h0000_0000_8000);

        // R5 no tick no change
        repeat (5) @(negedge clk);
        check_cnt("R5 idle", 48'h0000_0000_8000);

        // R3 carries
        set_cnt(48'h0000_0000_FFFF); burst(1);
        check_cnt("R3 low carry", 48'h0000_0001_0000);
        set_cnt(48'h0000_FFFF_FFFF); burst(1);
        check_cnt("R3 mid carry", 48'h0001_0000_0000);
        set_cnt(48'h1234_FFFF_FFFE); burst(3);
        check_cnt("R3 burst carry", 48'h1235_0000_0001);

        // R4 wrap
        set_cnt(48'hFFFF_FFFF_FFFF); burst(1);
        check_cnt("R4 wrap", 48'h0);

        // R5 single-word write
        set_cnt(48'h1111_2222_3333);
        wr(5'h02, 16'hBEEF);
        check_cnt("R5 word write", 48'h1111_BEEF_3333);

        // R6 write and tick together
        @(negedge clk);
        tick = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'h04; bus_wdata = 16'h5A5A;
        @(negedge clk);
        tick = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        check_cnt("R6 write wins", 48'h5A5A_BEEF_3333);

        // R7 compare readback
        set_cmp(48'hCAFE_F00D_7E57);
        rd(5'h08, d); check("R7 cmp0", d, 16'h7E57);
        rd(5'h0A, d); check("R7 cmp1", d, 16'hF00D);
        rd(5'h0C, d); check("R7 cmp2", d, 16'hCAFE);

        // R12 upper bits and unmapped offsets
        rd(5'h06, d); check("R12 hole06", d, 16'h0);
        rd(5'h0E, d); check("R12 hole0e", d, 16'h0);
        rd(5'h1E, d); check("R12 hole1e", d, 16'h0);

        // R8 / R9 / R10 alarm sweep across compare distances and a carry
        wr(5'h12, 16'hFFFF);
        rd(5'h12, d); check("R10 en read", d, 16'h0001);
        for (int k = 1; k <= 6; k++) begin
            logic [47:0] base;
            base = 48'h0000_0003_FFFC;
            set_cnt(base);
            set_cmp(base + 48'(k));
            wr(5'h10, 16'h0001);
            if (k > 1) begin
                burst(k - 1);
                @(negedge clk);
                rd(5'h10, d); check("R8 before match", d, 16'h0);
                check("R10 irq low", {15'h0, alarm_irq}, 16'h0);
                burst(1);
            end else begin
                burst(1);
            end
            @(negedge clk);
            rd(5'h10, d); check("R8 after match", d, 16'h0001);
            check("R10 irq high", {15'h0, alarm_irq}, 16'h0001);
            // R9 writing zero leaves it set
            wr(5'h10, 16'hFFFE);
            rd(5'h10, d); check("R9 w0 keeps", d, 16'h0001);
            // R11 clear while still equal stays clear
            wr(5'h10, 16'h0001);
            repeat (4) @(negedge clk);
            rd(5'h10, d); check("R11 stays clear", d, 16'h0);
            check("R9 irq after clear", {15'h0, alarm_irq}, 16'h0);
        end

        // R10 flag set with enable off gives no interrupt
        wr(5'h12, 16'h0000);
        set_cnt(48'h0000_0000_0100);
        set_cmp(48'h0000_0000_0101);
        wr(5'h10, 16'h0001);
        burst(1);
        @(negedge clk);
        rd(5'h10, d); check("R10 flag set", d, 16'h0001);
        check("R10 irq masked", {15'h0, alarm_irq}, 16'h0);
        wr(5'h12, 16'h0001);
        check("R10 irq unmasked", {15'h0, alarm_irq}, 16'h0001);

        // R9 set wins over a simultaneous clear
        wr(5'h10, 16'h0001);
        set_cnt(48'h0000_0000_0200);
        set_cmp(48'h0000_0000_0201);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'h10; bus_wdata = 16'h0001;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        rd(5'h10, d); check("R9 set wins", d, 16'h0001);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule